// File: doc/BRIEF.md
# PLL Configuration and Lock Timer

This block keeps the configuration of a clock generator's PLL and main oscillator and produces the two status flags that software waits on. The flags are PLL locked and oscillator stable. No analog loop is modelled. Each flag comes from a countdown that runs on a slow-clock tick. The tick reaches the block as a one-cycle enable pulse in the fast clock domain.

Software writes the PLL parameters in one 32-bit write: divider, multiplier, output range and lock count. The block reports the effective multiply factor, the divider and the range to the synthesis logic that follows it. A write that changes the multiplier or the divider drops the lock flag. The flag then comes back after the programmed number of slow ticks. The oscillator has an enable bit and a start-up count that is scaled by eight. Both flags can raise a shared interrupt through a mask that software sets and clears with write-one registers.

Top module: `pll_cfg_lock`

## Requirements
- R1: After reset `pll_lock_o`, `osc_stable_o`, `irq_o`, `irq_mask_o`, `pll_div_o` and `pll_mul_o` are all 0.
- R2: A write to address 1 loads the PLL fields. The divider is in bits 7:0, the lock count in bits 13:8, the range in bits 15:14 and the multiplier in bits 26:16. `pll_div_o` shows the divider and `pll_range_o` shows the range. When the PLL is on, `pll_mul_o` shows the multiplier field plus one.
- R3: When the multiplier or the divider field is 0, the PLL is off. `pll_mul_o` then reads 0 and `pll_lock_o` stays low.
- R4: A write that turns the PLL on, or that changes the multiplier or the divider, clears `pll_lock_o`. The flag rises in the cycle after the N-th later slow tick, where N is the lock count. A count of 0 gives lock in the cycle right after the write. A tick in the same cycle as the write is not counted.
- R5: A PLL write that leaves both the multiplier and the divider unchanged neither drops the lock flag nor restarts its countdown.
- R6: A write to address 0 with bit 0 set, while the oscillator is disabled, enables the oscillator. `osc_stable_o` then rises after 8×C slow ticks, where C is bits 15:8. A C of 0 gives stability at once.
- R7: A write to address 0 with bit 0 clear drops `osc_stable_o` in the next cycle. Writing bit 0 set again while the oscillator is already enabled does not restart the wait.
- R8: Writing ones to address 2 sets the matching mask bits. Writing ones to address 3 clears them. Zero bits leave the mask alone. Mask bit 0 belongs to oscillator stable and bit 1 to PLL lock.
- R9: `irq_o` is high exactly when a status flag is high and its mask bit is set.
- R10: Writing 0x00040805 gives a multiply factor of 5 and a divider of 5. Lock follows after eight slow ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 oscillator, 1 PLL, 2 mask set, 3 mask clear |
| wr_data_i | input | 32 | Write data |
| pll_mul_o | output | MUL_W+1 | Effective multiply factor, 0 when off |
| pll_div_o | output | DIV_W | Divider value |
| pll_range_o | output | RNG_W | Output range selection |
| pll_lock_o | output | 1 | PLL locked |
| osc_stable_o | output | 1 | Main oscillator stable |
| irq_mask_o | output | 2 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit divider, an 11-bit multiplier, a 6-bit lock count and an 8-bit oscillator count scaled by 8. It drives a slow tick every fourth cycle. The lock counts it writes (0, 2, 8 and 63) are short enough to watch the flag fall and rise several times. They also cover the zero-count case and a write that leaves the multiplier and divider alone. The oscillator wait of 16 ticks exercises the scale factor. Turning the PLL off through either field, and interrupts masked per source, are reached in the same run.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  typedef enum logic [1:0] {
    ADDR_OSC  = 2'd0,
    ADDR_PLL  = 2'd1,
    ADDR_MSET = 2'd2,
    ADDR_MCLR = 2'd3
  } reg_addr_e;

  localparam int DIV_LSB    = 0;
  localparam int LCNT_LSB   = 8;
  localparam int RNG_LSB    = 14;
  localparam int MUL_LSB    = 16;
  localparam int OSC_EN_BIT = 0;
  localparam int OCNT_LSB   = 8;

  localparam int IRQ_OSC  = 0;
  localparam int IRQ_LOCK = 1;
  localparam int IRQ_W    = 2;
endpackage

// File: rtl/slow_countdown.sv
module slow_countdown #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic         active_q;
  logic [W-1:0] rem_q;

  // load wins over clear so a write that turns the source on starts the wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      rem_q    <= load_val_i;
    end else if (clear_i) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (tick_i && (rem_q != '0)) begin
      rem_q    <= rem_q - 1'b1;
    end
  end

  assign done_o = active_q && (rem_q == '0);
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (set_i) mask_q <= mask_q | bits_i;
    else if (clr_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_i & mask_q);
endmodule

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock
  import pll_cfg_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int LCNT_W    = 6,
  parameter int RNG_W     = 2,
  parameter int MUL_W     = 11,
  parameter int OCNT_W    = 8,
  parameter int OSC_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  output logic [MUL_W:0]   pll_mul_o,
  output logic [DIV_W-1:0] pll_div_o,
  output logic [RNG_W-1:0] pll_range_o,
  output logic             pll_lock_o,
  output logic             osc_stable_o,
  output logic [IRQ_W-1:0] irq_mask_o,
  output logic             irq_o
);
  localparam int OTMR_W = OCNT_W + OSC_SHIFT;

  logic osc_wr, pll_wr, mset_wr, mclr_wr;
  assign osc_wr  = wr_en_i && (wr_addr_i == ADDR_OSC);
  assign pll_wr  = wr_en_i && (wr_addr_i == ADDR_PLL);
  assign mset_wr = wr_en_i && (wr_addr_i == ADDR_MSET);
  assign mclr_wr = wr_en_i && (wr_addr_i == ADDR_MCLR);

  // PLL configuration
  logic [DIV_W-1:0]  new_div, div_q;
  logic [MUL_W-1:0]  new_mul, mul_q;
  logic [RNG_W-1:0]  new_rng, rng_q;
  logic [LCNT_W-1:0] new_lcnt;
  logic              new_on, pll_on_q, pll_chg, pll_load, pll_done;

  assign new_div  = wr_data_i[DIV_LSB  +: DIV_W];
  assign new_lcnt = wr_data_i[LCNT_LSB +: LCNT_W];
  assign new_rng  = wr_data_i[RNG_LSB  +: RNG_W];
  assign new_mul  = wr_data_i[MUL_LSB  +: MUL_W];
  assign new_on   = (new_div != '0) && (new_mul != '0);
  assign pll_chg  = (new_div != div_q) || (new_mul != mul_q);
  assign pll_load = pll_wr && pll_chg && new_on;
  assign pll_on_q = (div_q != '0) && (mul_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      mul_q <= '0;
      rng_q <= '0;
    end else if (pll_wr) begin
      div_q <= new_div;
      mul_q <= new_mul;
      rng_q <= new_rng;
    end
  end

  slow_countdown #(.W(LCNT_W)) i_pll_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (!pll_on_q),
    .load_i     (pll_load),
    .load_val_i (new_lcnt),
    .tick_i     (slow_tick_i),
    .done_o     (pll_done)
  );

  assign pll_lock_o  = pll_done && pll_on_q;
  assign pll_mul_o   = pll_on_q ? ({1'b0, mul_q} + 1'b1) : '0;
  assign pll_div_o   = div_q;
  assign pll_range_o = rng_q;

  // main oscillator
  logic              osc_en_q, osc_load, osc_done;
  logic [OCNT_W-1:0] new_ocnt;
  logic [OTMR_W-1:0] osc_wait;

  assign new_ocnt = wr_data_i[OCNT_LSB +: OCNT_W];
  assign osc_wait = {new_ocnt, {OSC_SHIFT{1'b0}}};
  assign osc_load = osc_wr && wr_data_i[OSC_EN_BIT] && !osc_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     osc_en_q <= 1'b0;
    else if (osc_wr) osc_en_q <= wr_data_i[OSC_EN_BIT];
  end

  slow_countdown #(.W(OTMR_W)) i_osc_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (!osc_en_q),
    .load_i     (osc_load),
    .load_val_i (osc_wait),
    .tick_i     (slow_tick_i),
    .done_o     (osc_done)
  );

  assign osc_stable_o = osc_done && osc_en_q;

  // interrupt
  logic [IRQ_W-1:0] status;
  assign status[IRQ_OSC]  = osc_stable_o;
  assign status[IRQ_LOCK] = pll_lock_o;

  irq_mask_unit #(.W(IRQ_W)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (mset_wr),
    .clr_i    (mclr_wr),
    .bits_i   (wr_data_i[IRQ_W-1:0]),
    .status_i (status),
    .mask_o   (irq_mask_o),
    .irq_o    (irq_o)
  );

  logic unused_data;
  assign unused_data = ^wr_data_i[31:MUL_LSB+MUL_W];
endmodule

// File: rtl/pll_cfg_lock_chk.sv
module pll_cfg_lock_chk
  import pll_cfg_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int LCNT_W    = 6,
  parameter int RNG_W     = 2,
  parameter int MUL_W     = 11,
  parameter int OCNT_W    = 8,
  parameter int OSC_SHIFT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slow_tick_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [31:0]      wr_data_i,
  input logic [MUL_W:0]   pll_mul_o,
  input logic [DIV_W-1:0] pll_div_o,
  input logic [RNG_W-1:0] pll_range_o,
  input logic             pll_lock_o,
  input logic             osc_stable_o,
  input logic [IRQ_W-1:0] irq_mask_o,
  input logic             irq_o
);
  logic             pll_w, same_cfg, div_moves;
  logic [DIV_W-1:0] w_div;
  logic [MUL_W:0]   w_mul_eff;

  assign pll_w     = wr_en_i && (wr_addr_i == ADDR_PLL);
  assign w_div     = wr_data_i[DIV_LSB +: DIV_W];
  assign w_mul_eff = {1'b0, wr_data_i[MUL_LSB +: MUL_W]} + 1'b1;
  assign same_cfg  = (w_div == pll_div_o) && (w_mul_eff == pll_mul_o);
  assign div_moves = (w_div != pll_div_o) && (w_div != '0) &&
                     (wr_data_i[MUL_LSB +: MUL_W] != '0) &&
                     (wr_data_i[LCNT_LSB +: LCNT_W] != '0);

  assert_off_no_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_mul_o == '0) |-> !pll_lock_o);

  assert_relock_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_w && div_moves) |=> !pll_lock_o);

  assert_lock_rise_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_lock_o) |-> $past(slow_tick_i || wr_en_i));

  assert_keep_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_w && same_cfg && pll_lock_o) |=> pll_lock_o);

  assert_osc_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == ADDR_OSC) && !wr_data_i[OSC_EN_BIT]) |=> !osc_stable_o);

  assert_mask_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == ADDR_MSET)) |=>
      ((irq_mask_o & $past(wr_data_i[IRQ_W-1:0])) == $past(wr_data_i[IRQ_W-1:0])));

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_o == '0) |-> !irq_o);

  assert_irq_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_lock_o && irq_mask_o[IRQ_LOCK]) |-> irq_o);
endmodule

bind pll_cfg_lock pll_cfg_lock_chk #(
  .DIV_W(DIV_W), .LCNT_W(LCNT_W), .RNG_W(RNG_W),
  .MUL_W(MUL_W), .OCNT_W(OCNT_W), .OSC_SHIFT(OSC_SHIFT)
) i_chk (.*);

// File: tb/test_pll_cfg_lock.sv
`timescale 1ns/1ps
module test_pll_cfg_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [11:0] mul_o;
  logic [7:0]  div_o;
  logic [1:0]  rng_o;
  logic        lock_o, stab_o, irq_o;
  logic [1:0]  mask_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit tick_run = 1'b0;
  int tick_cnt = 0;

  always #4 clk = ~clk;

  pll_cfg_lock i_pll_cfg_lock (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pll_mul_o(mul_o), .pll_div_o(div_o), .pll_range_o(rng_o),
    .pll_lock_o(lock_o), .osc_stable_o(stab_o),
    .irq_mask_o(mask_o), .irq_o(irq_o)
  );

  // reference model state
  int m_div = 0, m_mul = 0, m_rng = 0, m_prem = 0, m_orem = 0;
  bit m_pact = 0, m_oen = 0, m_oact = 0;
  bit [1:0] m_mask = 0;

  function automatic bit m_pon();
    return (m_mul != 0) && (m_div != 0);
  endfunction

  always @(posedge clk) begin
    bit pon_old, pload, oload;
    int nd, nm;
    if (!rst_n) begin
      m_div = 0; m_mul = 0; m_rng = 0; m_prem = 0; m_orem = 0;
      m_pact = 0; m_oen = 0; m_oact = 0; m_mask = 0;
    end else begin
      pon_old = m_pon();
      nd = int'(wr_data[7:0]);
      nm = int'(wr_data[26:16]);
      pload = wr_en && wr_addr == 2'd1 && (nd != m_div || nm != m_mul) && nd != 0 && nm != 0;
      if (pload) begin m_pact = 1; m_prem = int'(wr_data[13:8]); end
      else if (!pon_old) m_pact = 0;
      else if (tick && m_prem > 0) m_prem--;
      if (wr_en && wr_addr == 2'd1) begin m_div = nd; m_mul = nm; m_rng = int'(wr_data[15:14]); end
      oload = wr_en && wr_addr == 2'd0 && wr_data[0] && !m_oen;
      if (oload) begin m_oact = 1; m_orem = 8 * int'(wr_data[15:8]); end
      else if (!m_oen) m_oact = 0;
      else if (tick && m_orem > 0) m_orem--;
      if (wr_en && wr_addr == 2'd0) m_oen = wr_data[0];
      if (wr_en && wr_addr == 2'd2) m_mask = m_mask | wr_data[1:0];
      if (wr_en && wr_addr == 2'd3) m_mask = m_mask & ~wr_data[1:0];
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle compare against the model
  always @(negedge clk) begin
    bit e_lock, e_stab;
    if (rst_n) begin
      e_lock = m_pon() && m_pact && m_prem == 0;
      e_stab = m_oen && m_oact && m_orem == 0;
      check("R4 lock", int'(lock_o), int'(e_lock));
      check("R6 stable", int'(stab_o), int'(e_stab));
      check("R2 div", int'(div_o), m_div);
      check("R2 range", int'(rng_o), m_rng);
      check("R3 mul", int'(mul_o), m_pon() ? m_mul + 1 : 0);
      check("R8 mask", int'(mask_o), int'(m_mask));
      check("R9 irq", int'(irq_o), int'((e_lock && m_mask[1]) || (e_stab && m_mask[0])));
    end
  end

  always @(negedge clk) begin
    if (tick_run) begin
      tick_cnt = (tick_cnt + 1) % 4;
      tick <= (tick_cnt == 0);
    end else tick <= 1'b0;
  end

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      finish_test();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 lock", int'(lock_o), 0);
    check("R1 stable", int'(stab_o), 0);
    check("R1 mask", int'(mask_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 mul", int'(mul_o), 0);
    check("R1 div", int'(div_o), 0);
    tick_run = 1'b1;

    wr(2'd2, 32'h3);
    check("R8 set both", int'(mask_o), 3);

    wr(2'd0, 32'h0000_0201);       // enable, 2*8 ticks
    check("R6 not yet stable", int'(stab_o), 0);
    idle(80);
    check("R6 stable after wait", int'(stab_o), 1);
    check("R9 irq from osc", int'(irq_o), 1);

    wr(2'd1, 32'h0004_0805);
    check("R10 mul", int'(mul_o), 5);
    check("R10 div", int'(div_o), 5);
    check("R10 lock low", int'(lock_o), 0);
    idle(40);
    check("R10 locked", int'(lock_o), 1);

    wr(2'd1, 32'h0004_3F05);       // same mul/div, new count
    check("R5 lock kept", int'(lock_o), 1);
    idle(10);
    check("R5 lock still kept", int'(lock_o), 1);

    wr(2'd1, 32'h0005_C203);       // div 3, mul field 5, range 3, count 2
    check("R4 lock dropped", int'(lock_o), 0);
    check("R2 mul", int'(mul_o), 6);
    check("R2 range", int'(rng_o), 3);
    idle(12);
    check("R4 relocked", int'(lock_o), 1);

    wr(2'd3, 32'h2);
    check("R8 clear lock bit", int'(mask_o), 1);

    wr(2'd1, 32'h0000_0003);       // mul 0
    check("R3 mul off", int'(mul_o), 0);
    check("R3 lock off", int'(lock_o), 0);
    idle(20);
    check("R3 stays unlocked", int'(lock_o), 0);

    wr(2'd1, 32'h0001_0007);       // count 0
    check("R4 zero count lock", int'(lock_o), 1);
    check("R2 mul two", int'(mul_o), 2);
    check("R9 lock masked", int'(irq_o), 1);

    wr(2'd0, 32'h0000_FF01);       // already enabled: no restart
    check("R7 no restart", int'(stab_o), 1);
    wr(2'd0, 32'h0000_0000);
    check("R7 disabled", int'(stab_o), 0);
    check("R9 irq low", int'(irq_o), 0);

    wr(2'd1, 32'h0000_0A00);       // div 0
    check("R3 div off lock", int'(lock_o), 0);
    idle(8);
    finish_test();
  end
endmodule